// File: doc/BRIEF.md
# UART Receiver with Error-Tagged Receive Queue

This block turns an asynchronous serial line into characters. The line is resynchronised to the core clock and then sampled only on cycles where a 16x rate enable is high. A falling edge starts a candidate frame. The candidate is confirmed only if the line is still low near the middle of the start bit. The receiver then collects 5 to 8 data bits, least-significant bit first. If parity is enabled it reads a parity bit, and it always reads one stop bit. Parity errors, framing errors and line breaks are recorded as flags that travel with each character.

Completed characters go into a storage queue. In queue mode the queue holds 16 entries. In character mode only one entry may be occupied, so it behaves as a single holding register. Character mode is the state after reset. The consumer reads through a valid/ready pair: an entry is removed on every clock edge where `rd_valid` and `rd_ready` are both high. `rd_valid` never depends on `rd_ready`, and holding `rd_ready` low only leaves the data in place. If a character completes while the storage is full, that character is discarded and the stored contents are kept. This is the only loss path, because the serial line cannot be stalled.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset `rd_valid`, `overrun` and `rx_req` are low and the storage is empty.
- R2: A low level seen on a 16x tick while idle is accepted as a start bit only if the line is still low on the eighth following tick. Otherwise the receiver returns to idle and stores nothing.
- R3: Data bits are sampled 16 ticks apart, least-significant bit first. `char_bits` selects the length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. The unused upper bits of `rd_data` read as zero.
- R4: With `parity_en` high, one parity bit follows the data. `parity_odd` = 0 selects even parity and 1 selects odd parity. `rd_perr` is set for a character whose bit does not match. It is always 0 when parity is off.
- R5: A character whose stop bit is sampled low has `rd_ferr` set. After such a frame the receiver waits for the line to return high before looking for a new start bit.
- R6: A frame in which the start bit, every data bit, the parity bit and the stop bit are all low stores exactly one entry. That entry has data 0, `rd_brk` = 1, `rd_ferr` = 1 and `rd_perr` = 0, however long the line then stays low.
- R7: With `fifo_mode` high, up to 16 characters are stored and read back in arrival order. The flags of the head entry are presented with its data.
- R8: With `fifo_mode` low, at most one character is stored.
- R9: When a character completes and no space is free, it is discarded, the stored entries are unchanged, and `overrun` is high for exactly one clock.
- R10: `rd_valid` is high exactly while storage is non-empty. An entry is removed on each edge where `rd_valid` and `rd_ready` are both high.
- R11: Any change of `fifo_mode` empties the storage.
- R12: `rx_req` follows `rd_valid` in character mode. In queue mode it is high when at least RX_TRIG (default 8) entries are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| char_bits | input | 2 | Data length code (00=5 … 11=8 bits) |
| parity_en | input | 1 | Expect a parity bit |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| fifo_mode | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| rd_ready | input | 1 | Consumer accepts the head entry |
| rd_valid | output | 1 | Storage is non-empty |
| rd_data | output | 8 | Head character, zero-extended |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry is a break |
| overrun | output | 1 | One-clock pulse when a character was dropped |
| rx_req | output | 1 | Service request to the consumer |

## Verification
The assertions assume that `tick16` is a single-cycle pulse, that the line-control inputs stay stable while a frame is in flight, and that `fifo_mode` changes only while no frame is completing. The bench generates the tick from a free-running divider every fourth clock. It changes the line-control settings and the mode only between frames, after the line has been idle for at least one bit time. It drives every serial bit for a whole 64-clock bit period, so each sample point falls well inside its bit.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_WAITHI
  } rx_state_e;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rx_s,
  input  logic      tick,
  input  logic [1:0] char_bits,
  input  logic      parity_en,
  input  logic      parity_odd,
  output logic      done,
  output rx_entry_t char_out
);
  localparam int TW   = $clog2(OSR);
  localparam int HALF = OSR / 2;

  rx_state_e     st;
  logic [TW-1:0] tcnt;
  logic [2:0]    bidx;
  logic [3:0]    len_q;
  logic          pen_q, podd_q, pbit_q, any_one;
  logic [7:0]    shreg;
  logic          done_q;
  rx_entry_t     out_q;
  logic [3:0]    nbits;
  logic          par_bad;

  assign nbits   = 4'd5 + {2'b00, char_bits};
  assign par_bad = pen_q & (^shreg ^ pbit_q ^ podd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      tcnt    <= '0;
      bidx    <= '0;
      len_q   <= 4'd8;
      pen_q   <= 1'b0;
      podd_q  <= 1'b0;
      pbit_q  <= 1'b0;
      any_one <= 1'b0;
      shreg   <= '0;
      done_q  <= 1'b0;
      out_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (tick && !rx_s) begin
            st   <= S_START;
            tcnt <= '0;
          end
        end
        S_START: begin
          if (tick) begin
            if (tcnt == TW'(HALF - 1)) begin
              if (rx_s) begin
                st <= S_IDLE;
              end else begin
                st      <= S_DATA;
                tcnt    <= '0;
                bidx    <= '0;
                shreg   <= '0;
                any_one <= 1'b0;
                pbit_q  <= 1'b0;
                len_q   <= nbits;
                pen_q   <= parity_en;
                podd_q  <= parity_odd;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        S_DATA: begin
          if (tick) begin
            if (tcnt == TW'(OSR - 1)) begin
              tcnt        <= '0;
              shreg[bidx] <= rx_s;
              if (rx_s) any_one <= 1'b1;
              if ({1'b0, bidx} == len_q - 4'd1) st <= pen_q ? S_PAR : S_STOP;
              else                               bidx <= bidx + 1'b1;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        S_PAR: begin
          if (tick) begin
            if (tcnt == TW'(OSR - 1)) begin
              tcnt   <= '0;
              pbit_q <= rx_s;
              if (rx_s) any_one <= 1'b1;
              st     <= S_STOP;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        S_STOP: begin
          if (tick) begin
            if (tcnt == TW'(OSR - 1)) begin
              tcnt   <= '0;
              done_q <= 1'b1;
              if (rx_s) begin
                out_q <= '{brk: 1'b0, ferr: 1'b0, perr: par_bad, data: shreg};
                st    <= S_IDLE;
              end else if (!any_one) begin
                out_q <= '{brk: 1'b1, ferr: 1'b1, perr: 1'b0, data: 8'h00};
                st    <= S_WAITHI;
              end else begin
                out_q <= '{brk: 1'b0, ferr: 1'b1, perr: par_bad, data: shreg};
                st    <= S_WAITHI;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        S_WAITHI: begin
          if (rx_s) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done     = done_q;
  assign char_out = out_q;
endmodule

// File: rtl/srx_store.sv
module srx_store #(
  parameter int WIDTH = 11,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [CW-1:0]    cap,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt_q;
  logic             push_ok, pop_ok;

  assign full    = (cnt_q >= cap);
  assign pop_ok  = pop && (cnt_q != '0);
  assign push_ok = push && (!full || pop_ok);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign count = cnt_q;
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import srx_pkg::*;
#(
  parameter int OSR     = 16,
  parameter int DEPTH   = 16,
  parameter int RX_TRIG = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic       tick16,
  input  logic [1:0] char_bits,
  input  logic       parity_en,
  input  logic       parity_odd,
  input  logic       fifo_mode,
  input  logic       rd_ready,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       rd_perr,
  output logic       rd_ferr,
  output logic       rd_brk,
  output logic       overrun,
  output logic       rx_req
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          rx_s;
  logic          s_done;
  rx_entry_t     s_char;
  rx_entry_t     head;
  logic [CW-1:0] st_count;
  logic [CW-1:0] cap;
  logic          st_full;
  logic          mode_q;
  logic          flush_req;
  logic          pop;
  logic          ovr_q;

  srx_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(rx_line),
    .q_sync (rx_s)
  );

  srx_framer #(.OSR(OSR)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_s      (rx_s),
    .tick      (tick16),
    .char_bits (char_bits),
    .parity_en (parity_en),
    .parity_odd(parity_odd),
    .done      (s_done),
    .char_out  (s_char)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_mode;
  end

  assign flush_req = (fifo_mode != mode_q);
  assign cap       = fifo_mode ? CW'(DEPTH) : CW'(1);
  assign pop       = rd_valid && rd_ready;

  srx_store #(.WIDTH(ENTRY_W), .DEPTH(DEPTH), .CW(CW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush_req),
    .cap   (cap),
    .push  (s_done),
    .wdata (s_char),
    .pop   (pop),
    .head  (head),
    .count (st_count),
    .full  (st_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= s_done && st_full && !pop && !flush_req;
  end

  assign rd_valid = (st_count != '0);
  assign rd_data  = head.data;
  assign rd_perr  = head.perr;
  assign rd_ferr  = head.ferr;
  assign rd_brk   = head.brk;
  assign overrun  = ovr_q;
  assign rx_req   = fifo_mode ? (st_count >= CW'(RX_TRIG)) : rd_valid;
endmodule

// File: rtl/serial_rx_fifo_checker.sv
module serial_rx_fifo_checker #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_mode,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [7:0]    rd_data,
  input logic          rd_brk,
  input logic          rd_ferr,
  input logic          rd_perr,
  input logic          overrun,
  input logic          s_done,
  input logic          st_full,
  input logic          flush_req,
  input logic [CW-1:0] st_count
);
  // R7: occupancy never exceeds the queue depth
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_count <= CW'(DEPTH));

  // R8: character mode never holds more than one entry
  p_char_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && !flush_req) |=> (fifo_mode || st_count <= CW'(1)));

  // R9: a completion into full storage without a read raises overrun next cycle
  p_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_done && st_full && !(rd_valid && rd_ready) && !flush_req) |=> overrun);

  // R9: a dropped character leaves the occupancy unchanged
  p_ovr_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_done && st_full && !(rd_valid && rd_ready) && !flush_req) |=> $stable(st_count));

  // R10: a handshake without a new character removes one entry
  p_pop_dec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !s_done && !flush_req) |=> (st_count == $past(st_count) - 1'b1));

  // R6: a break entry is all-zero, framed and without parity error
  p_brk_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_brk) |-> (rd_data == 8'h00 && rd_ferr && !rd_perr));

  // R11: a mode change empties the storage
  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (st_count == '0));
endmodule

bind serial_rx_fifo serial_rx_fifo_checker #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fifo_mode(fifo_mode),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data),
  .rd_brk   (rd_brk),
  .rd_ferr  (rd_ferr),
  .rd_perr  (rd_perr),
  .overrun  (overrun),
  .s_done   (s_done),
  .st_full  (st_full),
  .flush_req(flush_req),
  .st_count (st_count)
);

// File: tb/serial_rx_fifo_bench.sv
`timescale 1ns/1ps
module serial_rx_fifo_bench;
  localparam int BT = 64;  // clocks per bit: 16 ticks, one tick every 4 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       tick16 = 1'b0;
  logic [1:0] char_bits = 2'b11;
  logic       parity_en = 1'b0;
  logic       parity_odd = 1'b0;
  logic       fifo_mode = 1'b0;
  logic       rd_ready = 1'b0;
  logic       rd_valid, rd_perr, rd_ferr, rd_brk, overrun, rx_req;
  logic [7:0] rd_data;

  int tests = 0;
  int fails = 0;
  int ovr_cnt = 0;
  logic [1:0] tdiv = '0;

  always #2.5 clk = ~clk;

  serial_rx_fifo u_serial_rx_fifo (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
    .char_bits(char_bits), .parity_en(parity_en), .parity_odd(parity_odd),
    .fifo_mode(fifo_mode), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
    .overrun(overrun), .rx_req(rx_req)
  );

  always @(negedge clk) begin
    tdiv   <= tdiv + 1'b1;
    tick16 <= (tdiv == 2'd3);
    if (rst_n && overrun) ovr_cnt <= ovr_cnt + 1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bits(input int n);
    repeat (n * BT) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit flip_par, input bit stop_val);
    logic [7:0] dm;
    logic       p;
    dm = d & 8'((1 << nb) - 1);
    rx_line = 1'b0; bits(1);
    for (int i = 0; i < nb; i++) begin rx_line = d[i]; bits(1); end
    if (parity_en) begin
      p = (^dm) ^ parity_odd ^ flip_par;
      rx_line = p; bits(1);
    end
    rx_line = stop_val; bits(1);
    rx_line = 1'b1; bits(1);
  endtask

  task automatic pop_one();
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_head(input string req, input int d, input int pe, input int fe, input int bk);
    check(req, "valid", rd_valid, 1);
    check(req, "data", rd_data, d);
    check(req, "perr", rd_perr, pe);
    check(req, "ferr", rd_ferr, fe);
    check(req, "brk", rd_brk, bk);
  endtask

  task automatic t_reset();
    check("R1", "valid after reset", rd_valid, 0);
    check("R1", "overrun after reset", overrun, 0);
    check("R1", "req after reset", rx_req, 0);
  endtask

  task automatic t_basic();
    send(8'hA5, 8, 0, 1);
    expect_head("R3", 'hA5, 0, 0, 0);
    check("R12", "req char mode", rx_req, 1);
    pop_one();
    check("R10", "valid after pop", rd_valid, 0);
  endtask

  task automatic t_lengths();
    char_bits = 2'b00;
    send(8'hFF, 5, 0, 1);
    expect_head("R3", 'h1F, 0, 0, 0);
    pop_one();
    char_bits = 2'b01;
    send(8'h2D, 6, 0, 1);
    expect_head("R3", 'h2D, 0, 0, 0);
    pop_one();
    char_bits = 2'b11;
  endtask

  task automatic t_parity();
    char_bits = 2'b10; parity_en = 1'b1; parity_odd = 1'b0;
    send(8'h53, 7, 0, 1);
    expect_head("R4", 'h53, 0, 0, 0);
    pop_one();
    parity_odd = 1'b1;
    send(8'h6A, 7, 0, 1);
    expect_head("R4", 'h6A, 0, 0, 0);
    pop_one();
    send(8'h6A, 7, 1, 1);
    expect_head("R4", 'h6A, 1, 0, 0);
    pop_one();
    parity_en = 1'b0; parity_odd = 1'b0; char_bits = 2'b11;
  endtask

  task automatic t_framing();
    send(8'h55, 8, 0, 0);
    expect_head("R5", 'h55, 0, 1, 0);
    pop_one();
    send(8'h3C, 8, 0, 1);
    expect_head("R5", 'h3C, 0, 0, 0);
    pop_one();
  endtask

  task automatic t_break();
    rx_line = 1'b0; bits(14);
    rx_line = 1'b1; bits(2);
    expect_head("R6", 0, 0, 1, 1);
    pop_one();
    check("R6", "single break entry", rd_valid, 0);
  endtask

  task automatic t_glitch();
    rx_line = 1'b0;
    repeat (12) @(negedge clk);
    rx_line = 1'b1;
    bits(12);
    check("R2", "glitch stores nothing", rd_valid, 0);
    send(8'h81, 8, 0, 1);
    expect_head("R2", 'h81, 0, 0, 0);
    pop_one();
  endtask

  task automatic t_char_overrun();
    int base;
    base = ovr_cnt;
    send(8'h11, 8, 0, 1);
    send(8'h22, 8, 0, 1);
    check("R9", "overrun pulses", ovr_cnt - base, 1);
    expect_head("R8", 'h11, 0, 0, 0);
    pop_one();
    check("R8", "single holding entry", rd_valid, 0);
  endtask

  task automatic t_fifo();
    int base;
    fifo_mode = 1'b1; parity_en = 1'b1; parity_odd = 1'b0;
    bits(1);
    base = ovr_cnt;
    for (int i = 0; i < 17; i++) begin
      send(8'(i * 13 + 1), 8, (i == 5), 1);
      if (i == 6) check("R12", "req below trigger", rx_req, 0);
      if (i == 7) check("R12", "req at trigger", rx_req, 1);
    end
    check("R9", "fifo overrun pulses", ovr_cnt - base, 1);
    for (int i = 0; i < 16; i++) begin
      expect_head("R7", (i * 13 + 1) & 8'hFF, (i == 5) ? 1 : 0, 0, 0);
      pop_one();
    end
    check("R10", "empty after drain", rd_valid, 0);
    parity_en = 1'b0;
  endtask

  task automatic t_flush();
    send(8'h5A, 8, 0, 1);
    send(8'hC3, 8, 0, 1);
    check("R7", "two stored", rd_valid, 1);
    fifo_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R11", "flushed on mode change", rd_valid, 0);
    check("R11", "req after flush", rx_req, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    bits(1);
    t_basic();
    t_lengths();
    t_parity();
    t_framing();
    t_break();
    t_glitch();
    t_char_overrun();
    fifo_mode = 1'b1;
    bits(1);
    t_fifo();
    fifo_mode = 1'b1;
    bits(1);
    t_flush();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule